// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a core-side request port and a cache controller and keeps track of every memory request that is still in flight. It holds two small fully associative tables, one for requests that may modify a line and one for pure reads, both keyed by cache-line address. For each new request it answers in the same cycle with one of four statuses. The request can be accepted and recorded. It can be refused because its line is already pending. It can be refused because the tracker is at capacity. It can be refused because the access would run past the end of its line.

When the cache controller reports that a line has finished, the matching entry is released and the number of cycles it spent outstanding is reported on the following cycle. Four counters record why requests were turned away as aliases. A periodic watchdog checks the age of every entry and raises a one-cycle deadlock pulse when any entry has been pending for the configured threshold or longer. A lookup miss on completion, or a deadlock, sets a sticky error flag that only reset clears.

Top module: `inflight_req_tracker`

## Requirements
- R1: Request kinds are encoded on `req_kind` as 0 load, 1 instruction fetch, 2 store, 3 RMW-read, 4 RMW-write, 5 locked-read, 6 locked-write; kinds 2 to 6 are tracked in the write table and kinds 0 and 1 in the read table. A completion names its table with `cpl_is_write` (1 = write table).
- R2: Entries are keyed by the line address `req_addr[ADDR_W-1:log2(LINE_BYTES)]`; two requests differing only in offset bits refer to the same entry.
- R3: A valid request whose line is pending in the write table gets status 1 (aliased), `req_accept` stays 0 and nothing is allocated.
- R4: A request whose line is absent from the write table but pending in the read table also gets status 1 and allocates nothing.
- R5: Alias detection takes priority over capacity. A non-aliased request gets status 2 (full) when the outstanding count is at or above `MAX_OUT`, or when its own table has no free slot.
- R6: On a write-table alias, `stall_wr_by_rd` counts a new load, fetch or RMW-read and `stall_wr_by_wr` counts any other kind. On a read-table alias, `stall_rd_by_wr` counts a new store or RMW-write and `stall_rd_by_rd` counts any other kind.
- R7: A request whose offset within the line plus `req_len` exceeds `LINE_BYTES` gets status 3 and is never accepted; this check precedes all others.
- R8: A completion that finds its line frees the entry. On the next cycle `lat_valid` is 1 and `lat_cycles` equals the number of clock edges from the allocating edge to the completing edge. A zero latency is never reported.
- R9: A completion takes effect before an allocation in the same cycle: the freed line no longer aliases, and the freed slot and count are available to the new request.
- R10: A watchdog arms on the first allocation and checks every `AGE_LIMIT` cycles while entries remain. `deadlock` pulses for one cycle when any entry's age has reached `AGE_LIMIT`. An entry never completed raises it exactly `AGE_LIMIT` edges after its allocating edge, if the watchdog was idle when it was allocated.
- R11: `outstanding` always equals the combined occupancy of both tables. It rises by one on an accept and falls by one on a successful completion.
- R12: A completion whose line is absent from the named table, or a deadlock pulse, sets `err_sticky`, which stays 1 until reset.
- R13: Synchronous active-low reset empties both tables and clears the outstanding count, the stall counters, the latency output, `deadlock` and `err_sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A new request is presented this cycle |
| req_kind | input | 3 | Request kind, encoding in R1 |
| req_addr | input | ADDR_W | Byte address of the request |
| req_len | input | LEN_W | Access length in bytes |
| req_status | output | 2 | 0 ready, 1 aliased, 2 full, 3 oversize (combinational) |
| req_accept | output | 1 | The request is recorded at this clock edge |
| cpl_valid | input | 1 | A line completion is reported this cycle |
| cpl_is_write | input | 1 | Completion targets the write table |
| cpl_line | input | ADDR_W-log2(LINE_BYTES) | Line address being completed |
| lat_valid | output | 1 | Latency report valid (registered) |
| lat_cycles | output | TIME_W | Cycles the completed entry was outstanding |
| outstanding | output | log2(RD_DEPTH+WR_DEPTH+1) | Entries currently held |
| stall_wr_by_rd | output | STAT_W | Write-table aliases by reading kinds |
| stall_wr_by_wr | output | STAT_W | Write-table aliases by other kinds |
| stall_rd_by_wr | output | STAT_W | Read-table aliases by store or RMW-write |
| stall_rd_by_rd | output | STAT_W | Read-table aliases by other kinds |
| deadlock | output | 1 | One-cycle pulse when the watchdog finds an aged entry |
| err_sticky | output | 1 | Sticky error flag |

## Verification
The assertions watch, on every cycle, that the outstanding count matches the two tables' occupancies and moves by one per accept. They also check that no line is held twice in one table, that an allocation never finds its table without room, that an accept only happens below the limit, and that the error flag never drops. Which status each kind pairing produces, which stall counter it moves, the exact latency and deadlock cycles, the oversize boundary and the same-cycle free-then-allocate ordering depend on stimulus, so only the bench's sweeps over kinds, offsets, lengths and delays can show them.

// File: rtl/irt_pkg.sv
`timescale 1ns/1ps
// Package for the outstanding request tracker: request kinds and status codes.
package irt_pkg;

    typedef enum logic [2:0] {
        K_LOAD    = 3'd0,
        K_FETCH   = 3'd1,
        K_STORE   = 3'd2,
        K_RMW_RD  = 3'd3,
        K_RMW_WR  = 3'd4,
        K_LOCK_RD = 3'd5,
        K_LOCK_WR = 3'd6
    } req_kind_e;

    typedef enum logic [1:0] {
        ST_READY    = 2'd0,
        ST_ALIAS    = 2'd1,
        ST_FULL     = 2'd2,
        ST_OVERSIZE = 2'd3
    } req_status_e;

endpackage

// File: rtl/irt_classify.sv
`timescale 1ns/1ps
// Request classifier.
// Does: maps a request kind onto its table and onto the stall-cause groups,
//       and checks that the access stays inside one line.
// Assumes: LEN_W is wide enough to hold LINE_BYTES; unused kind code 7 is
//          treated as a read-table kind.
module irt_classify #(
    parameter int OFF_W      = 4,
    parameter int LEN_W      = 5,
    parameter int LINE_BYTES = 16
) (
    input  logic [2:0]       kind,
    input  logic [OFF_W-1:0] offset,
    input  logic [LEN_W-1:0] len,
    output logic             to_write_tbl,
    output logic             reads_line,
    output logic             writes_line,
    output logic             size_ok
);
    import irt_pkg::*;

    localparam int SUM_W = ((LEN_W > OFF_W) ? LEN_W : OFF_W) + 1;

    logic [SUM_W-1:0] end_byte;

    // Decode the kind into table choice and stall groups.
    always_comb begin
        to_write_tbl = 1'b0;
        reads_line   = 1'b0;
        writes_line  = 1'b0;
        case (kind)
            K_STORE:   begin to_write_tbl = 1'b1; writes_line = 1'b1; end
            K_RMW_RD:  begin to_write_tbl = 1'b1; reads_line  = 1'b1; end
            K_RMW_WR:  begin to_write_tbl = 1'b1; writes_line = 1'b1; end
            K_LOCK_RD: to_write_tbl = 1'b1;
            K_LOCK_WR: to_write_tbl = 1'b1;
            default:   reads_line = 1'b1;
        endcase
    end

    // Bound check: the last byte must fall inside the line.
    always_comb begin
        end_byte = SUM_W'(offset) + SUM_W'(len);
        size_ok  = (end_byte <= SUM_W'(LINE_BYTES));
    end

endmodule

// File: rtl/irt_table.sv
`timescale 1ns/1ps
// Fully associative pending-line table.
// Does: holds up to DEPTH line addresses with their issue stamps, answers a
//       lookup, frees on completion and allocates into the first free slot.
//       A completion frees its slot before the allocation of the same cycle.
// Assumes: alloc_en is raised only when has_room is 1 and lk_hit is 0.
module irt_table #(
    parameter int DEPTH     = 4,
    parameter int LINE_W    = 8,
    parameter int TIME_W    = 16,
    parameter int CNT_W     = 4,
    parameter int AGE_LIMIT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now,
    input  logic [LINE_W-1:0] lk_line,
    input  logic              alloc_en,
    input  logic              cpl_en,
    input  logic [LINE_W-1:0] cpl_line,
    output logic              lk_hit,
    output logic              has_room,
    output logic              cpl_hit,
    output logic [TIME_W-1:0] cpl_stamp,
    output logic [CNT_W-1:0]  count,
    output logic              any_aged
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]  valid_q;
    logic [LINE_W-1:0] line_q  [DEPTH];
    logic [TIME_W-1:0] stamp_q [DEPTH];

    logic [DEPTH-1:0]  lk_match;
    logic [DEPTH-1:0]  freeing;
    logic [DEPTH-1:0]  avail;
    logic [DEPTH-1:0]  aged;
    logic [IDX_W-1:0]  slot;

    // Per-entry compare against the lookup and completion lines, and age test.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        logic [TIME_W-1:0] age;
        assign age         = now - stamp_q[i];
        assign lk_match[i] = valid_q[i] && (line_q[i] == lk_line);
        assign freeing[i]  = cpl_en && valid_q[i] && (line_q[i] == cpl_line);
        assign avail[i]    = !valid_q[i] || freeing[i];
        assign aged[i]     = valid_q[i] && (age >= TIME_W'(AGE_LIMIT));
    end

    // Lookup view after this cycle's completion has been applied.
    always_comb begin
        lk_hit   = |(lk_match & ~freeing);
        has_room = |avail;
        cpl_hit  = |freeing;
        any_aged = |aged;
        count    = CNT_W'($countones(valid_q));
    end

    // Pick the lowest free slot and the stamp of the completing entry.
    always_comb begin
        slot      = '0;
        cpl_stamp = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (avail[i]) slot = IDX_W'(i);
            if (freeing[i]) cpl_stamp = cpl_stamp | stamp_q[i];
        end
    end

    // Entry state: free on completion, then allocate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                line_q[i]  <= '0;
                stamp_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (freeing[i]) valid_q[i] <= 1'b0;
                if (alloc_en && (slot == IDX_W'(i))) begin
                    valid_q[i] <= 1'b1;
                    line_q[i]  <= lk_line;
                    stamp_q[i] <= now;
                end
            end
        end
    end

    AST_UNIQUE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lk_match) <= 1); // R2

    AST_ALLOC_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> (has_room && !lk_hit)); // R5

endmodule

// File: rtl/irt_watchdog.sv
`timescale 1ns/1ps
// Age watchdog.
// Does: arms on an allocation while idle, counts AGE_LIMIT cycles, then
//       samples the tables' aged flags and pulses deadlock for one cycle;
//       re-arms while entries remain, otherwise goes idle.
// Assumes: AGE_LIMIT >= 2.
module irt_watchdog #(
    parameter int AGE_LIMIT = 64,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [CNT_W-1:0] count_next,
    input  logic             any_aged,
    output logic             deadlock
);
    localparam int TMR_W = $clog2(AGE_LIMIT + 1);

    logic [TMR_W-1:0] tmr_q;

    // Period timer and check strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q    <= '0;
            deadlock <= 1'b0;
        end else begin
            deadlock <= 1'b0;
            if (tmr_q == '0) begin
                if (alloc) tmr_q <= TMR_W'(AGE_LIMIT);
            end else if (tmr_q == TMR_W'(1)) begin
                deadlock <= any_aged;
                tmr_q    <= (count_next != '0) ? TMR_W'(AGE_LIMIT) : '0;
            end else begin
                tmr_q <= tmr_q - TMR_W'(1);
            end
        end
    end

    AST_DEADLOCK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        deadlock |=> !deadlock); // R10

endmodule

// File: rtl/inflight_req_tracker.sv
`timescale 1ns/1ps
// Outstanding memory request tracker (top).
// Does: classifies each request, checks it for aliasing against the read and
//       write tables, enforces the occupancy limit, records issue cycles,
//       reports completion latency, counts alias stalls by cause and runs the
//       age watchdog.
// Assumes: at most one request and one completion per cycle; a completion is
//          applied before the request of the same cycle.
module inflight_req_tracker #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int LEN_W      = 7,
    parameter int RD_DEPTH   = 8,
    parameter int WR_DEPTH   = 8,
    parameter int MAX_OUT    = 12,
    parameter int AGE_LIMIT  = 1000,
    parameter int TIME_W     = 32,
    parameter int STAT_W     = 32
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         req_valid,
    input  logic [2:0]                                   req_kind,
    input  logic [ADDR_W-1:0]                            req_addr,
    input  logic [LEN_W-1:0]                             req_len,
    output logic [1:0]                                   req_status,
    output logic                                         req_accept,
    input  logic                                         cpl_valid,
    input  logic                                         cpl_is_write,
    input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]         cpl_line,
    output logic                                         lat_valid,
    output logic [TIME_W-1:0]                            lat_cycles,
    output logic [$clog2(RD_DEPTH+WR_DEPTH+1)-1:0]       outstanding,
    output logic [STAT_W-1:0]                            stall_wr_by_rd,
    output logic [STAT_W-1:0]                            stall_wr_by_wr,
    output logic [STAT_W-1:0]                            stall_rd_by_wr,
    output logic [STAT_W-1:0]                            stall_rd_by_rd,
    output logic                                         deadlock,
    output logic                                         err_sticky
);
    import irt_pkg::*;

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam int CNT_W  = $clog2(RD_DEPTH + WR_DEPTH + 1);

    logic [TIME_W-1:0] now_q;
    logic [LINE_W-1:0] req_line;
    logic              to_wr, reads_line, writes_line, size_ok;
    logic              rd_hit, wr_hit, rd_room, wr_room;
    logic              rd_cpl_hit, wr_cpl_hit, cpl_hit;
    logic [TIME_W-1:0] rd_stamp, wr_stamp, lat_now;
    logic [CNT_W-1:0]  rd_cnt, wr_cnt, cnt_after_cpl, cnt_next;
    logic              rd_aged, wr_aged, over_limit;
    req_status_e       status;

    assign req_line = req_addr[ADDR_W-1:OFF_W];

    irt_classify #(.OFF_W(OFF_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)) u_classify (
        .kind         (req_kind),
        .offset       (req_addr[OFF_W-1:0]),
        .len          (req_len),
        .to_write_tbl (to_wr),
        .reads_line   (reads_line),
        .writes_line  (writes_line),
        .size_ok      (size_ok)
    );

    irt_table #(.DEPTH(RD_DEPTH), .LINE_W(LINE_W), .TIME_W(TIME_W),
                .CNT_W(CNT_W), .AGE_LIMIT(AGE_LIMIT)) u_rd_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .now       (now_q),
        .lk_line   (req_line),
        .alloc_en  (req_accept && !to_wr),
        .cpl_en    (cpl_valid && !cpl_is_write),
        .cpl_line  (cpl_line),
        .lk_hit    (rd_hit),
        .has_room  (rd_room),
        .cpl_hit   (rd_cpl_hit),
        .cpl_stamp (rd_stamp),
        .count     (rd_cnt),
        .any_aged  (rd_aged)
    );

    irt_table #(.DEPTH(WR_DEPTH), .LINE_W(LINE_W), .TIME_W(TIME_W),
                .CNT_W(CNT_W), .AGE_LIMIT(AGE_LIMIT)) u_wr_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .now       (now_q),
        .lk_line   (req_line),
        .alloc_en  (req_accept && to_wr),
        .cpl_en    (cpl_valid && cpl_is_write),
        .cpl_line  (cpl_line),
        .lk_hit    (wr_hit),
        .has_room  (wr_room),
        .cpl_hit   (wr_cpl_hit),
        .cpl_stamp (wr_stamp),
        .count     (wr_cnt),
        .any_aged  (wr_aged)
    );

    irt_watchdog #(.AGE_LIMIT(AGE_LIMIT), .CNT_W(CNT_W)) u_watchdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc      (req_accept),
        .count_next (cnt_next),
        .any_aged   (rd_aged || wr_aged),
        .deadlock   (deadlock)
    );

    // Completion result and post-completion occupancy.
    always_comb begin
        cpl_hit       = cpl_is_write ? wr_cpl_hit : rd_cpl_hit;
        lat_now       = now_q - (cpl_is_write ? wr_stamp : rd_stamp);
        cnt_after_cpl = outstanding - CNT_W'(cpl_hit);
        over_limit    = (32'(cnt_after_cpl) >= MAX_OUT);
        cnt_next      = cnt_after_cpl + CNT_W'(req_accept);
    end

    // Status priority: oversize, write alias, read alias, capacity.
    always_comb begin
        status = ST_READY;
        if (!size_ok)                               status = ST_OVERSIZE;
        else if (wr_hit || rd_hit)                  status = ST_ALIAS;
        else if (over_limit || !(to_wr ? wr_room : rd_room)) status = ST_FULL;
        req_status = req_valid ? status : ST_READY;
        req_accept = req_valid && (status == ST_READY);
    end

    // Cycle stamp, occupancy, latency report, stall counters and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_q          <= '0;
            outstanding    <= '0;
            lat_valid      <= 1'b0;
            lat_cycles     <= '0;
            stall_wr_by_rd <= '0;
            stall_wr_by_wr <= '0;
            stall_rd_by_wr <= '0;
            stall_rd_by_rd <= '0;
            err_sticky     <= 1'b0;
        end else begin
            now_q       <= now_q + TIME_W'(1);
            outstanding <= cnt_next;
            lat_valid   <= cpl_valid && cpl_hit && (lat_now != '0);
            lat_cycles  <= lat_now;
            if (req_valid && size_ok && wr_hit) begin
                if (reads_line) stall_wr_by_rd <= stall_wr_by_rd + STAT_W'(1);
                else            stall_wr_by_wr <= stall_wr_by_wr + STAT_W'(1);
            end else if (req_valid && size_ok && rd_hit) begin
                if (writes_line) stall_rd_by_wr <= stall_rd_by_wr + STAT_W'(1);
                else             stall_rd_by_rd <= stall_rd_by_rd + STAT_W'(1);
            end
            if ((cpl_valid && !cpl_hit) || deadlock) err_sticky <= 1'b1;
        end
    end

    AST_COUNT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding == (rd_cnt + wr_cnt)); // R11

    AST_ACCEPT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept && !(cpl_valid && cpl_hit)) |=> outstanding == $past(outstanding) + CNT_W'(1)); // R11

    AST_ACCEPT_BELOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        req_accept |-> (32'(rd_cnt) + 32'(wr_cnt) - 32'(cpl_valid && cpl_hit)) < MAX_OUT); // R5

    AST_ERR_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky); // R12

    AST_LAT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lat_valid |-> lat_cycles != '0); // R8

endmodule

// File: tb/test_inflight_req_tracker.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps kind pairings, offsets and lengths, delays and
// capacity corners against arithmetically computed expectations.
module test_inflight_req_tracker;

    localparam int AW = 12, LB = 16, LW = 5, RD = 4, WD = 4, MX = 6, AG = 40;
    localparam int TW = 12, SW = 16, OW = 4, CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_kind = '0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic [1:0]    req_status;
    logic          req_accept;
    logic          cpl_valid = 1'b0;
    logic          cpl_is_write = 1'b0;
    logic [AW-OW-1:0] cpl_line = '0;
    logic          lat_valid;
    logic [TW-1:0] lat_cycles;
    logic [CW-1:0] outstanding;
    logic [SW-1:0] stall_wr_by_rd, stall_wr_by_wr, stall_rd_by_wr, stall_rd_by_rd;
    logic          deadlock, err_sticky;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    inflight_req_tracker #(
        .ADDR_W(AW), .LINE_BYTES(LB), .LEN_W(LW), .RD_DEPTH(RD), .WR_DEPTH(WD),
        .MAX_OUT(MX), .AGE_LIMIT(AG), .TIME_W(TW), .STAT_W(SW)
    ) i_inflight_req_tracker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_len(req_len), .req_status(req_status),
        .req_accept(req_accept), .cpl_valid(cpl_valid), .cpl_is_write(cpl_is_write),
        .cpl_line(cpl_line), .lat_valid(lat_valid), .lat_cycles(lat_cycles),
        .outstanding(outstanding), .stall_wr_by_rd(stall_wr_by_rd),
        .stall_wr_by_wr(stall_wr_by_wr), .stall_rd_by_wr(stall_rd_by_wr),
        .stall_rd_by_rd(stall_rd_by_rd), .deadlock(deadlock), .err_sticky(err_sticky)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic present(input int kind, input int addr, input int len,
                           output int st, output int acc);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'(kind); req_addr = AW'(addr); req_len = LW'(len);
        #1 st = int'(req_status); acc = int'(req_accept);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic complete(input bit wr, input int line);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_is_write = wr; cpl_line = (AW-OW)'(line);
        @(posedge clk);
        #1 cpl_valid = 1'b0;
    endtask

    task automatic both(input bit wr, input int line, input int kind, input int addr,
                        output int st, output int acc);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_is_write = wr; cpl_line = (AW-OW)'(line);
        req_valid = 1'b1; req_kind = 3'(kind); req_addr = AW'(addr); req_len = LW'(1);
        #1 st = int'(req_status); acc = int'(req_accept);
        @(posedge clk);
        #1 cpl_valid = 1'b0; req_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish actual=0 expected=1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int st, acc;
        int e_wl, e_ww, e_rw, e_rr;
        e_wl = 0; e_ww = 0; e_rw = 0; e_rr = 0;

        // R13: reset state
        do_reset();
        check("R13 outstanding", int'(outstanding), 0);
        check("R13 err_sticky", int'(err_sticky), 0);
        check("R13 deadlock", int'(deadlock), 0);
        check("R13 lat_valid", int'(lat_valid), 0);
        check("R13 stalls", int'(stall_wr_by_rd) + int'(stall_wr_by_wr)
              + int'(stall_rd_by_wr) + int'(stall_rd_by_rd), 0);

        // R1 R2 R3 R4 R6 R8: every pending kind against every new kind
        for (int a = 0; a < 7; a++) begin
            for (int b = 0; b < 7; b++) begin
                int line;
                line = 1 + a * 7 + b;
                present(a, line * LB, 4, st, acc);
                check("R1 first request accepted", acc, 1);
                check("R11 outstanding after accept", int'(outstanding), 1);
                present(b, line * LB + ((b + 3) % LB), 1, st, acc);
                check("R2 R3 R4 alias status", st, 1);
                check("R3 R4 alias not accepted", acc, 0);
                if (a >= 2) begin
                    if (b == 0 || b == 1 || b == 3) e_wl++; else e_ww++;
                end else begin
                    if (b == 2 || b == 4) e_rw++; else e_rr++;
                end
                check("R6 stall_wr_by_rd", int'(stall_wr_by_rd), e_wl);
                check("R6 stall_wr_by_wr", int'(stall_wr_by_wr), e_ww);
                check("R6 stall_rd_by_wr", int'(stall_rd_by_wr), e_rw);
                check("R6 stall_rd_by_rd", int'(stall_rd_by_rd), e_rr);
                complete(a >= 2, line);
                check("R1 completion finds entry in its table", int'(err_sticky), 0);
                check("R8 lat_valid", int'(lat_valid), 1);
                check("R8 latency two edges", int'(lat_cycles), 2);
                check("R11 outstanding after completion", int'(outstanding), 0);
            end
        end

        // R8: latency over a range of delays
        for (int k = 0; k < 6; k++) begin
            present(0, (100 + k) * LB, 2, st, acc);
            repeat (k) @(posedge clk);
            complete(1'b0, 100 + k);
            check("R8 latency k+1", int'(lat_cycles), k + 1);
            check("R8 lat_valid", int'(lat_valid), 1);
        end
        @(posedge clk); #1;
        check("R8 lat_valid drops", int'(lat_valid), 0);

        // R7: every offset against every length
        do_reset();
        for (int off = 0; off < LB; off++) begin
            for (int len = 0; len <= LB; len++) begin
                present(1, 200 * LB + off, len, st, acc);
                check("R7 size status", st, (off + len <= LB) ? 0 : 3);
                if (acc == 1) complete(1'b0, 200);
            end
        end
        check("R7 nothing left", int'(outstanding), 0);

        // R5 R9: capacity corners
        do_reset();
        for (int i = 0; i < 4; i++) begin
            present(0, (10 + i) * LB, 1, st, acc);
            check("R5 fill read table", acc, 1);
        end
        present(0, 14 * LB, 1, st, acc);
        check("R5 read table has no room", st, 2);
        present(2, 20 * LB, 1, st, acc);
        check("R5 store into write table", acc, 1);
        present(6, 21 * LB, 1, st, acc);
        check("R5 locked-write into write table", acc, 1);
        check("R11 outstanding at max", int'(outstanding), 6);
        present(4, 22 * LB, 1, st, acc);
        check("R5 at max gives full", st, 2);
        present(1, 10 * LB + 5, 1, st, acc);
        check("R5 alias beats full", st, 1);
        both(1'b0, 10, 0, 10 * LB + 2, st, acc);
        check("R9 freed line not aliased", st, 0);
        check("R9 freed line accepted", acc, 1);
        check("R9 outstanding unchanged", int'(outstanding), 6);
        both(1'b0, 11, 2, 23 * LB, st, acc);
        check("R9 freed count lets store in", acc, 1);
        check("R11 outstanding still 6", int'(outstanding), 6);

        // R12: completion for an absent line
        complete(1'b1, 77);
        check("R12 absent completion flags", int'(err_sticky), 1);
        repeat (5) @(posedge clk); #1;
        check("R12 flag sticks", int'(err_sticky), 1);
        do_reset();
        check("R13 reset clears flag", int'(err_sticky), 0);

        // R10: aged entry raises deadlock exactly AG edges after allocation
        present(2, 30 * LB, 1, st, acc);
        repeat (AG - 1) @(posedge clk);
        #1 check("R10 no deadlock before threshold", int'(deadlock), 0);
        @(posedge clk);
        #1 check("R10 deadlock at threshold", int'(deadlock), 1);
        @(posedge clk);
        #1 check("R10 deadlock is a pulse", int'(deadlock), 0);
        check("R12 deadlock sets flag", int'(err_sticky), 1);

        // R10: entry completed in time raises nothing
        do_reset();
        present(0, 31 * LB, 1, st, acc);
        repeat (10) @(posedge clk);
        complete(1'b0, 31);
        repeat (3 * AG) @(posedge clk);
        #1 check("R10 no deadlock for completed entry", int'(err_sticky), 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule